// File: doc/BRIEF.md
# PCI Single-Beat Target Front End

This block sits on a 32-bit PCI bus as a target only. It watches each address phase and claims the cycle when two things are true: the address falls inside a window given by the upper address bits of a base input, and the command is a memory or I/O read or write. It then passes the access to a slower back-end engine. It never starts a PCI cycle of its own.

Writes are posted. Address, data, byte enables and the I/O flag go into a small FIFO, and the PCI data phase completes at once. Reads hold TRDY# high until the back end returns the whole 32-bit word. A read is only requested once every posted write has drained, so the back end sees accesses in order. Every claimed data phase carries STOP#, so an initiator that tries to burst moves exactly one word per transaction. The block drives even parity on the read data it returns. It checks parity on the address phase and on write data, pulses PERR# and keeps a sticky error flag.

Top module: `pci_single_target`

## Requirements
- R1: After reset, TRDY#, STOP#, DEVSEL# and PERR# are high, ad_oe and par_oe are low, wb_valid and rd_req are low, and perr_sticky is low.
- R2: A cycle is claimed only when ad_in[31:WIN_BITS] equals bar_base and the C/BE# command is 4'b0010 (I/O read), 4'b0011 (I/O write), 4'b0110 (memory read) or 4'b0111 (memory write). For any other cycle, DEVSEL# and TRDY# stay high until FRAME# and IRDY# are both high.
- R3: Take the rising edge where FRAME# is first sampled low as edge 0. DEVSEL# of a claimed cycle is still high after edge 1 and is low after edge 2. TRDY# is never low while DEVSEL# is high.
- R4: On a claimed write with buffer space, TRDY# goes low after edge 2. The edge that samples IRDY# and TRDY# both low stores {io flag, C/BE#, address, data} in the write buffer.
- R5: TRDY# is never low without STOP# low. A transaction that keeps FRAME# low (burst) therefore moves exactly one word. TRDY# goes high at the transfer edge. STOP# and DEVSEL# go high on the first edge after that where FRAME# is sampled high.
- R6: A claimed write that finds the buffer full (WB_DEPTH entries) gets a retry: STOP# low with TRDY# high. Nothing is stored.
- R7: The buffer presents entries in arrival order on wb_valid/wb_addr/wb_data/wb_be_n/wb_io and drops the head on an edge with wb_pop high. A push and a pop on the same edge both take effect.
- R8: On a claimed read, rd_req is high with rd_addr equal to the captured address and rd_io high for I/O reads. TRDY# stays high until the edge that samples rd_ack. After that edge, TRDY# and STOP# are low and ad_out holds rd_data with ad_oe high.
- R9: rd_req stays low while the write buffer holds any entry. TRDY# stays high during that time.
- R10: In the clock after a read transfer edge, par_oe is high for one cycle and par_out equals the XOR of the transferred ad_out word and C/BE#.
- R11: par_in is compared one edge after the address edge and one edge after a write transfer edge, against the XOR of the AD and C/BE# values captured there. A mismatch drives PERR# low for one clock, starting at the second edge after the phase.
- R12: perr_sticky goes high together with any PERR# pulse and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bar_base | input | 32-WIN_BITS | Upper address bits of the claimed window |
| frame_n | input | 1 | FRAME# from the initiator |
| irdy_n | input | 1 | IRDY# from the initiator |
| ad_in | input | 32 | AD bus as received |
| cbe_n | input | 4 | C/BE# bus as received |
| par_in | input | 1 | PAR as received |
| ad_out | output | 32 | Read data driven onto AD |
| ad_oe | output | 1 | Output enable for ad_out |
| par_out | output | 1 | Generated PAR for read data |
| par_oe | output | 1 | Output enable for par_out |
| trdy_n | output | 1 | TRDY# |
| stop_n | output | 1 | STOP# |
| devsel_n | output | 1 | DEVSEL# |
| perr_n | output | 1 | PERR# pulse on a parity mismatch |
| perr_sticky | output | 1 | Sticky parity error flag |
| wb_valid | output | 1 | Write buffer head is valid |
| wb_addr | output | 32 | Head entry address |
| wb_data | output | 32 | Head entry data |
| wb_be_n | output | 4 | Head entry byte enables, active low |
| wb_io | output | 1 | Head entry is an I/O write |
| wb_pop | input | 1 | Back end consumes the head entry |
| rd_req | output | 1 | Read request to the back end |
| rd_addr | output | 32 | Read request address |
| rd_io | output | 1 | Read request is an I/O read |
| rd_ack | input | 1 | Back end returns the read word |
| rd_data | input | 32 | Read word from the back end |

## Verification
A posted write can be pushed into the buffer on the same edge that the back end pops the previous entry. The bench sets this up by parking one entry and then making the back-end model pop exactly when it sees TRDY# low for a second write. It then checks that one entry remains, that it is the second write, and that both come out in order. A read that arrives while the buffer is non-empty races with draining. The bench holds the pop off, confirms that rd_req and TRDY# stay high, then releases the pop and checks that the read completes with the modelled data.

// File: rtl/pci_tgt_pkg.sv
package pci_tgt_pkg;

  localparam int ADW = 32;
  localparam int BEW = 4;

  typedef struct packed {
    logic           io;
    logic [BEW-1:0] be_n;
    logic [ADW-1:0] addr;
    logic [ADW-1:0] data;
  } wb_entry_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DEC1, ST_DEC2, ST_WR, ST_RDW, ST_RDX, ST_END, ST_SKIP
  } tgt_state_e;

  // even parity over one AD/C-BE phase
  function automatic logic even_par(input logic [ADW-1:0] d, input logic [BEW-1:0] be);
    return ^{d, be};
  endfunction

  // memory or I/O, read or write: 0010 0011 0110 0111
  function automatic logic cmd_fwd(input logic [BEW-1:0] c);
    return (c[3] == 1'b0) && (c[1] == 1'b1);
  endfunction

  function automatic logic cmd_wr(input logic [BEW-1:0] c);
    return c[0];
  endfunction

  function automatic logic cmd_io(input logic [BEW-1:0] c);
    return !c[2];
  endfunction

endpackage

// File: rtl/tgt_addr_dec.sv
module tgt_addr_dec
  import pci_tgt_pkg::*;
#(
  parameter int WIN_BITS = 16
) (
  input  logic [ADW-1:0]        addr,
  input  logic [BEW-1:0]        cmd,
  input  logic [ADW-1:WIN_BITS] base,
  output logic                  hit,
  output logic                  is_wr,
  output logic                  is_io
);

  function automatic logic in_window(input logic [ADW-1:0] a, input logic [ADW-1:WIN_BITS] b);
    return a[ADW-1:WIN_BITS] == b;
  endfunction

  assign hit   = in_window(addr, base) && cmd_fwd(cmd);
  assign is_wr = cmd_wr(cmd);
  assign is_io = cmd_io(cmd);

endmodule

// File: rtl/tgt_par_chk.sv
module tgt_par_chk
  import pci_tgt_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           arm,
  input  logic [ADW-1:0] ad,
  input  logic [BEW-1:0] be,
  input  logic           par_in,
  output logic           perr_n,
  output logic           sticky
);

  logic           armed_q;
  logic [ADW-1:0] ad_q;
  logic [BEW-1:0] be_q;
  logic           err_q;
  logic           mismatch;

  assign mismatch = armed_q && (even_par(ad_q, be_q) != par_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      ad_q    <= '0;
      be_q    <= '0;
      err_q   <= 1'b0;
      perr_n  <= 1'b1;
      sticky  <= 1'b0;
    end else begin
      armed_q <= arm;
      if (arm) begin
        ad_q <= ad;
        be_q <= be;
      end
      err_q  <= mismatch;
      perr_n <= !err_q;
      if (err_q) sticky <= 1'b1;
    end
  end

  // R11
  perr_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !perr_n |-> sticky);

  // R11
  perr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !perr_n |=> perr_n || $past(mismatch));

  // R12
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sticky |=> sticky);

endmodule

// File: rtl/tgt_wbuf.sv
module tgt_wbuf
  import pci_tgt_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      push,
  input  wb_entry_t din,
  input  logic      pop,
  output wb_entry_t head,
  output logic      valid,
  output logic      full
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  wb_entry_t       mem [DEPTH];
  logic [PW-1:0]   wp, rp;
  logic [CW-1:0]   cnt;
  logic            do_pop;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign do_pop = pop && valid;
  assign valid  = (cnt != '0);
  assign full   = (cnt == CW'(DEPTH));
  assign head   = mem[rp];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push)   wp <= nxt(wp);
      if (do_pop) rp <= nxt(rp);
      cnt <= cnt + CW'(push) - CW'(do_pop);
    end
  end

  // R6
  wb_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

  // R7
  wb_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && do_pop) |=> cnt == $past(cnt));

endmodule

// File: rtl/pci_single_target.sv
module pci_single_target
  import pci_tgt_pkg::*;
#(
  parameter int WIN_BITS = 16,
  parameter int WB_DEPTH = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADW-1:WIN_BITS] bar_base,
  input  logic                  frame_n,
  input  logic                  irdy_n,
  input  logic [ADW-1:0]        ad_in,
  input  logic [BEW-1:0]        cbe_n,
  input  logic                  par_in,
  output logic [ADW-1:0]        ad_out,
  output logic                  ad_oe,
  output logic                  par_out,
  output logic                  par_oe,
  output logic                  trdy_n,
  output logic                  stop_n,
  output logic                  devsel_n,
  output logic                  perr_n,
  output logic                  perr_sticky,
  output logic                  wb_valid,
  output logic [ADW-1:0]        wb_addr,
  output logic [ADW-1:0]        wb_data,
  output logic [BEW-1:0]        wb_be_n,
  output logic                  wb_io,
  input  logic                  wb_pop,
  output logic                  rd_req,
  output logic [ADW-1:0]        rd_addr,
  output logic                  rd_io,
  input  logic                  rd_ack,
  input  logic [ADW-1:0]        rd_data
);

  tgt_state_e     st;
  logic [ADW-1:0] addr_q, ad_q;
  logic           hit_q, wr_q, io_q;
  logic           dec_hit, dec_wr, dec_io;
  logic           wb_full, wb_vld;
  wb_entry_t      wb_head, wb_in;

  // named events
  logic addr_ph, wr_xfer, rd_xfer, rd_go, par_arm;

  assign addr_ph = (st == ST_IDLE) && !frame_n;
  assign wr_xfer = (st == ST_WR)   && !irdy_n;
  assign rd_xfer = (st == ST_RDX)  && !irdy_n;
  assign rd_go   = (st == ST_RDW)  && rd_ack && !wb_vld;
  assign par_arm = addr_ph || wr_xfer;

  assign wb_in = '{io: io_q, be_n: cbe_n, addr: addr_q, data: ad_in};

  tgt_addr_dec #(.WIN_BITS(WIN_BITS)) u_dec (
    .addr  (ad_in),
    .cmd   (cbe_n),
    .base  (bar_base),
    .hit   (dec_hit),
    .is_wr (dec_wr),
    .is_io (dec_io)
  );

  tgt_wbuf #(.DEPTH(WB_DEPTH)) u_wbuf (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (wr_xfer),
    .din   (wb_in),
    .pop   (wb_pop),
    .head  (wb_head),
    .valid (wb_vld),
    .full  (wb_full)
  );

  tgt_par_chk u_par (
    .clk    (clk),
    .rst_n  (rst_n),
    .arm    (par_arm),
    .ad     (ad_in),
    .be     (cbe_n),
    .par_in (par_in),
    .perr_n (perr_n),
    .sticky (perr_sticky)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      addr_q   <= '0;
      ad_q     <= '0;
      hit_q    <= 1'b0;
      wr_q     <= 1'b0;
      io_q     <= 1'b0;
      ad_oe    <= 1'b0;
      par_out  <= 1'b0;
      par_oe   <= 1'b0;
      trdy_n   <= 1'b1;
      stop_n   <= 1'b1;
      devsel_n <= 1'b1;
    end else begin
      par_oe <= 1'b0;
      unique case (st)
        ST_IDLE: if (!frame_n) begin
          addr_q <= ad_in;
          hit_q  <= dec_hit;
          wr_q   <= dec_wr;
          io_q   <= dec_io;
          st     <= ST_DEC1;
        end
        ST_DEC1: st <= hit_q ? ST_DEC2 : ST_SKIP;
        ST_DEC2: begin
          devsel_n <= 1'b0;
          if (!wr_q) begin
            st <= ST_RDW;
          end else if (wb_full) begin
            stop_n <= 1'b0;
            st     <= ST_END;
          end else begin
            stop_n <= 1'b0;
            trdy_n <= 1'b0;
            st     <= ST_WR;
          end
        end
        ST_WR: if (!irdy_n) begin
          trdy_n <= 1'b1;
          if (frame_n) begin
            stop_n   <= 1'b1;
            devsel_n <= 1'b1;
            st       <= ST_IDLE;
          end else begin
            st <= ST_END;
          end
        end
        ST_RDW: if (rd_go) begin
          ad_q   <= rd_data;
          ad_oe  <= 1'b1;
          trdy_n <= 1'b0;
          stop_n <= 1'b0;
          st     <= ST_RDX;
        end
        ST_RDX: if (!irdy_n) begin
          trdy_n  <= 1'b1;
          ad_oe   <= 1'b0;
          par_out <= even_par(ad_q, cbe_n);
          par_oe  <= 1'b1;
          if (frame_n) begin
            stop_n   <= 1'b1;
            devsel_n <= 1'b1;
            st       <= ST_IDLE;
          end else begin
            st <= ST_END;
          end
        end
        ST_END: if (frame_n) begin
          stop_n   <= 1'b1;
          devsel_n <= 1'b1;
          st       <= ST_IDLE;
        end
        ST_SKIP: if (frame_n && irdy_n) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign ad_out   = ad_q;
  assign rd_req   = (st == ST_RDW) && !wb_vld;
  assign rd_addr  = addr_q;
  assign rd_io    = io_q;
  assign wb_valid = wb_vld;
  assign wb_addr  = wb_head.addr;
  assign wb_data  = wb_head.data;
  assign wb_be_n  = wb_head.be_n;
  assign wb_io    = wb_head.io;

  // R5
  trdy_with_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !trdy_n |-> !stop_n);

  // R3
  trdy_claimed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !trdy_n |-> !devsel_n);

  // R2
  devsel_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !devsel_n |-> hit_q);

  // R8
  rd_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_xfer |-> ad_oe);

  // R9
  rd_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ad_oe) |-> !$past(wb_vld));

  // R10
  par_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    par_oe |=> !par_oe);

endmodule

// File: tb/tb_pci_single_target.sv
`timescale 1ns/1ps
module tb_pci_single_target;

  localparam int WIN = 16;
  localparam logic [31:0] BAR = 32'h4000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_n = 1'b1, irdy_n = 1'b1, par_in = 1'b0;
  logic [31:0] ad_in = '0;
  logic [3:0]  cbe_n = '1;
  logic [31:0] ad_out, wb_addr, wb_data, rd_addr;
  logic [31:0] rd_data = '0;
  logic [3:0]  wb_be_n;
  logic        ad_oe, par_out, par_oe, trdy_n, stop_n, devsel_n, perr_n, perr_sticky;
  logic        wb_valid, wb_io, rd_req, rd_io;
  logic        wb_pop = 1'b0, rd_ack = 1'b0;

  int n_chk = 0, n_fail = 0;
  bit pop_en = 0, pop_on_trdy = 0, done = 0;
  logic [68:0] exp_q[$];
  logic [68:0] exp_item;
  int lat_cnt = 0;

  always #4 clk = ~clk;

  pci_single_target #(.WIN_BITS(WIN), .WB_DEPTH(2)) dut (
    .clk(clk), .rst_n(rst_n), .bar_base(BAR[31:WIN]), .frame_n(frame_n), .irdy_n(irdy_n),
    .ad_in(ad_in), .cbe_n(cbe_n), .par_in(par_in), .ad_out(ad_out), .ad_oe(ad_oe),
    .par_out(par_out), .par_oe(par_oe), .trdy_n(trdy_n), .stop_n(stop_n), .devsel_n(devsel_n),
    .perr_n(perr_n), .perr_sticky(perr_sticky), .wb_valid(wb_valid), .wb_addr(wb_addr),
    .wb_data(wb_data), .wb_be_n(wb_be_n), .wb_io(wb_io), .wb_pop(wb_pop), .rd_req(rd_req),
    .rd_addr(rd_addr), .rd_io(rd_io), .rd_ack(rd_ack), .rd_data(rd_data)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [68:0] act, input logic [68:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rd_model(input logic [31:0] a, input bit io);
    return (a * 32'h9E37_79B1) ^ (io ? 32'h0F0F_0F0F : 32'h5A00_00A5);
  endfunction

  function automatic bit claims(input logic [31:0] a, input logic [3:0] c);
    return (a[31:WIN] == BAR[31:WIN]) &&
           (c == 4'h2 || c == 4'h3 || c == 4'h6 || c == 4'h7);
  endfunction

  // scoreboard monitor for the write buffer (R7)
  always @(negedge clk) begin
    if (rst_n && wb_valid && (pop_en || (pop_on_trdy && !trdy_n))) begin
      if (exp_q.size() == 0) begin
        chk(0, "R7", "unexpected buffer entry", {wb_io, wb_be_n, wb_addr, wb_data}, '0);
      end else begin
        exp_item = exp_q.pop_front();
        chk({wb_io, wb_be_n, wb_addr, wb_data} === exp_item, "R7", "buffer entry order",
            {wb_io, wb_be_n, wb_addr, wb_data}, exp_item);
      end
      wb_pop = 1'b1;
    end else begin
      wb_pop = 1'b0;
    end
  end

  // back-end read model
  always @(negedge clk) begin
    if (rd_ack) begin
      rd_ack = 1'b0;
    end else if (rd_req) begin
      if (lat_cnt == 3) begin
        rd_ack  = 1'b1;
        rd_data = rd_model(rd_addr, rd_io);
        lat_cnt = 0;
      end else begin
        lat_cnt++;
      end
    end
  end

  task automatic pci_cycle(input logic [31:0] addr, input logic [3:0] cmd,
                           input logic [31:0] data, input logic [3:0] be,
                           input bit burst, input bit bad_ap, input bit bad_dp,
                           output int res);
    bit claim, wr, io, seen_req;
    logic [31:0] rdata;
    claim = claims(addr, cmd);
    wr = cmd[0]; io = !cmd[2]; res = 0; seen_req = 0; rdata = '0;
    @(negedge clk);
    frame_n = 1'b0; irdy_n = 1'b1; ad_in = addr; cbe_n = cmd;
    @(negedge clk);
    frame_n = burst ? 1'b0 : 1'b1; irdy_n = 1'b0;
    ad_in = wr ? data : 32'h0; cbe_n = be;
    par_in = (^{addr, cmd}) ^ bad_ap;
    @(negedge clk);
    chk(devsel_n === 1'b1, "R3", "DEVSEL# before second edge", devsel_n, 1);
    par_in = 1'b0;
    @(negedge clk);
    chk(perr_n === !bad_ap, "R11", "address PERR#", perr_n, !bad_ap);
    if (!claim) begin
      repeat (4) begin
        chk(devsel_n === 1'b1 && trdy_n === 1'b1, "R2", "unclaimed cycle", {devsel_n, trdy_n}, 2'b11);
        @(negedge clk);
      end
      frame_n = 1'b1; irdy_n = 1'b1;
    end else begin
      chk(devsel_n === 1'b0, "R3", "DEVSEL# after second edge", devsel_n, 0);
      for (int i = 0; i < 300; i++) begin
        if (!wr && rd_req && !seen_req) begin
          seen_req = 1;
          chk(rd_addr === addr && rd_io === io, "R8", "read request", {rd_io, rd_addr}, {io, addr});
        end
        if (!trdy_n) begin
          chk(stop_n === 1'b0, "R5", "STOP# with TRDY#", stop_n, 0);
          if (wr) exp_q.push_back({io, be, addr, data});
          else begin
            rdata = ad_out;
            chk(ad_oe === 1'b1, "R8", "read AD enable", ad_oe, 1);
          end
          @(negedge clk);
          if (wr) par_in = (^{data, be}) ^ bad_dp;
          else begin
            chk(par_oe === 1'b1 && par_out === ^{rdata, be}, "R10", "read PAR",
                {par_oe, par_out}, {1'b1, ^{rdata, be}});
            chk(rdata === rd_model(addr, io), "R8", "read data", rdata, rd_model(addr, io));
          end
          chk(trdy_n === 1'b1, "R5", "TRDY# released after one beat", trdy_n, 1);
          frame_n = 1'b1; irdy_n = 1'b1;
          res = 1;
          break;
        end
        if (!stop_n && trdy_n) begin
          frame_n = 1'b1; irdy_n = 1'b1;
          res = 2;
          break;
        end
        @(negedge clk);
      end
      if (res == 1 && wr) begin
        @(negedge clk);
        par_in = 1'b0;
        chk(perr_n === 1'b1, "R11", "no early data PERR#", perr_n, 1);
        @(negedge clk);
        chk(perr_n === !bad_dp, "R11", "data PERR#", perr_n, !bad_dp);
      end
    end
    @(negedge clk);
    @(negedge clk);
    chk(devsel_n === 1'b1 && stop_n === 1'b1, "R5", "bus released", {devsel_n, stop_n}, 2'b11);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int r;
    repeat (3) @(negedge clk);
    // R1
    chk(trdy_n === 1 && stop_n === 1 && devsel_n === 1 && perr_n === 1, "R1", "reset handshake",
        {trdy_n, stop_n, devsel_n, perr_n}, 4'hF);
    chk(ad_oe === 0 && par_oe === 0 && wb_valid === 0 && rd_req === 0 && perr_sticky === 0,
        "R1", "reset outputs", {ad_oe, par_oe, wb_valid, rd_req, perr_sticky}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    pop_en = 1;

    // R4 posted writes, memory and I/O
    pci_cycle(32'h4000_0010, 4'h7, 32'hDEAD_BEEF, 4'h0, 0, 0, 0, r);
    chk(r == 1, "R4", "memory write posted", r, 1);
    pci_cycle(32'h4000_0204, 4'h3, 32'h0000_12A5, 4'hC, 0, 0, 0, r);
    chk(r == 1, "R4", "I/O write posted", r, 1);

    // R8 reads
    pci_cycle(32'h4000_0100, 4'h6, 32'h0, 4'h0, 0, 0, 0, r);
    chk(r == 1, "R8", "memory read done", r, 1);
    pci_cycle(32'h4000_0061, 4'h2, 32'h0, 4'hE, 0, 0, 0, r);
    chk(r == 1, "R8", "I/O read done", r, 1);

    // R5 bursts cut to one beat
    pci_cycle(32'h4000_8000, 4'h7, 32'hCAFE_F00D, 4'h3, 1, 0, 0, r);
    chk(r == 1, "R5", "burst write single beat", r, 1);
    pci_cycle(32'h4000_8040, 4'h6, 32'h0, 4'h0, 1, 0, 0, r);
    chk(r == 1, "R5", "burst read single beat", r, 1);

    // R2 not claimed
    pci_cycle(32'h4001_0000, 4'h7, 32'h1111_2222, 4'h0, 0, 0, 0, r);
    chk(r == 0, "R2", "outside window", r, 0);
    pci_cycle(32'h4000_0000, 4'hA, 32'h0, 4'h0, 0, 0, 0, r);
    chk(r == 0, "R2", "config command ignored", r, 0);
    pci_cycle(32'h4000_0020, 4'hC, 32'h0, 4'h0, 0, 0, 0, r);
    chk(r == 0, "R2", "read-multiple ignored", r, 0);
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0 && wb_valid === 0, "R2", "nothing posted by ignored writes", exp_q.size(), 0);

    // R9 read waits for the buffer to drain
    pop_en = 0;
    pci_cycle(32'h4000_0300, 4'h7, 32'hA1B2_C3D4, 4'h0, 0, 0, 0, r);
    fork
      begin
        pci_cycle(32'h4000_0304, 4'h6, 32'h0, 4'h0, 0, 0, 0, r);
        chk(r == 1, "R9", "read after drain", r, 1);
      end
      begin
        repeat (8) @(negedge clk);
        chk(rd_req === 0 && trdy_n === 1, "R9", "read held while buffer busy", {rd_req, trdy_n}, 2'b01);
        pop_en = 1;
      end
    join

    // R7 push and pop on the same edge
    pop_en = 0;
    pci_cycle(32'h4000_0400, 4'h7, 32'h0101_0101, 4'h0, 0, 0, 0, r);
    pop_on_trdy = 1;
    pci_cycle(32'h4000_0404, 4'h3, 32'h0202_0202, 4'h5, 0, 0, 0, r);
    pop_on_trdy = 0;
    chk(wb_valid === 1 && wb_data === 32'h0202_0202 && wb_io === 1, "R7", "push with pop keeps newer entry",
        {wb_valid, wb_io, wb_data}, {2'b11, 32'h0202_0202});
    pop_en = 1;
    repeat (4) @(negedge clk);

    // R6 retry on full buffer
    pop_en = 0;
    pci_cycle(32'h4000_0500, 4'h7, 32'h5555_0001, 4'h0, 0, 0, 0, r);
    pci_cycle(32'h4000_0504, 4'h7, 32'h5555_0002, 4'h0, 0, 0, 0, r);
    pci_cycle(32'h4000_0508, 4'h7, 32'h5555_0003, 4'h0, 0, 0, 0, r);
    chk(r == 2, "R6", "retry when full", r, 2);
    pop_en = 1;
    repeat (6) @(negedge clk);
    chk(exp_q.size() == 0 && wb_valid === 0, "R6", "only accepted writes drained", exp_q.size(), 0);

    // R11 / R12 parity errors
    chk(perr_sticky === 0, "R12", "sticky clear before errors", perr_sticky, 0);
    pci_cycle(32'h4000_0600, 4'h7, 32'h7777_8888, 4'h0, 0, 1, 0, r);
    chk(perr_sticky === 1, "R12", "sticky after address error", perr_sticky, 1);
    pci_cycle(32'h4000_0604, 4'h7, 32'h9999_AAAA, 4'h9, 0, 0, 1, r);
    pci_cycle(32'h4002_0000, 4'h6, 32'h0, 4'h0, 0, 1, 0, r);
    pci_cycle(32'h4000_0608, 4'h6, 32'h0, 4'h0, 0, 0, 0, r);
    chk(perr_sticky === 1, "R12", "sticky held after clean cycles", perr_sticky, 1);

    repeat (6) @(negedge clk);
    chk(exp_q.size() == 0 && wb_valid === 0, "R7", "all posted writes consumed", exp_q.size(), 0);
    finish_run();
  end

endmodule